// File: doc/BRIEF.md
# Tiled Block-Transfer Address Stepper

This block produces the three memory addresses a rectangular block-transfer engine needs on every pixel: one for the destination, one for the source and one for the pattern. A `start` pulse captures the operation's settings. These are the three start addresses, a line pitch per operand, the X and Y direction bits, the tile wrap selections of the source and pattern, and the X and Y counts. After that, each `step` pulse advances one pixel. The block also reports when a line ends and when the whole rectangle has been covered.

The source and the pattern can each be a small tile that repeats. The tile's width and height are powers of two. In X, the in-tile column wraps inside the tile. In Y, the operand's line address moves back to the top of the tile after the last tile row, or to the bottom when running upward. The destination always advances linearly. The block computes no pixel data and performs no memory access.

Top module: `blit_addr_stepper`

## Requirements
- R1: After reset, all three addresses are 0 and `x_ovf`, `y_ovf` and `done` are 0.
- R2: A `start` pulse clears the flags and the X/Y positions. Per operand, it splits the start address as follows. The in-tile column is the address bits under the X tile mask (tile width 2^sel, mask 2^sel-1). With Y wrap, the in-tile row is (address with column bits removed) >> xsel, masked to tile height 2^ysel-1, and the line address is the start address with its low xsel+ysel bits cleared. Without Y wrap, the line address is the start address with only the column bits removed. The output address is always line address + column, modulo 2^22, visible the cycle after the edge.
- R3: A step that does not end a line moves every operand's column by +1 (`x_neg`=0) or -1 (`x_neg`=1). An operand with X wrap keeps the column inside its tile mask.
- R4: The X position runs from 0 to `x_count` inclusive. The step taken at X = `x_count` ends the line: X returns to 0, every column reloads its start value, and `x_ovf` is 1 until the next accepted step.
- R5: At a line end, the destination line address moves by `dst_pitch`+1 from the saved line start: up when `y_neg`=0, down when `y_neg`=1.
- R6: With `y_neg`=0, each wrapped operand adds pitch+1 to its line address and increments its in-tile row. When the row passes 2^ysel-1, the row becomes 0 and the line address drops by (pitch+1)*2^ysel.
- R7: With `y_neg`=1, each wrapped operand subtracts pitch+1 and decrements its row. When the row is 0 before the step, it reloads to 2^ysel-1 and the line address rises by (pitch+1)*2^ysel.
- R8: The line end taken at Y = `y_count` sets `x_ovf`, `y_ovf` and `done` together and leaves all three addresses unchanged.
- R9: While `done` is 1, steps change neither the addresses nor the flags. Only `start` clears `done`.
- R10: A wrap selection of 7 (all ones) disables wrapping on that axis, and the operand advances linearly.
- R11: All addresses wrap modulo 2^22.
- R12: When `start` and `step` are both high in a cycle, only the start takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture settings and begin an operation |
| step | input | 1 | Advance one pixel |
| dst_base | input | 22 | Destination start address |
| src_base | input | 22 | Source start address |
| pat_base | input | 22 | Pattern start address |
| dst_pitch | input | 12 | Destination line offset minus 1 |
| src_pitch | input | 12 | Source line offset minus 1 |
| pat_pitch | input | 12 | Pattern line offset minus 1 |
| x_neg | input | 1 | X runs downward |
| y_neg | input | 1 | Y runs downward |
| src_xwrap | input | 3 | Source tile width select (2^n, 7 = none) |
| src_ywrap | input | 3 | Source tile height select (2^n, 7 = none) |
| pat_xwrap | input | 3 | Pattern tile width select (2^n, 7 = none) |
| pat_ywrap | input | 3 | Pattern tile height select (2^n, 7 = none) |
| x_count | input | 12 | Last X position |
| y_count | input | 12 | Last Y position |
| dst_addr | output | 22 | Current destination address |
| src_addr | output | 22 | Current source address |
| pat_addr | output | 22 | Current pattern address |
| x_ovf | output | 1 | Last accepted step ended a line |
| y_ovf | output | 1 | Last accepted step ended the rectangle |
| done | output | 1 | Operation finished |

## Verification
On every cycle, the assertions check four things. The X position stays within its count. Wrapped columns and rows stay inside their tiles. Addresses hold still when nothing advances. The finished state holds its flags and never shows a rectangle end without a line end. Only the bench's scenarios can show that the addresses themselves are right. That covers the start-time split of each address into tile parts, the tile corrections in both Y directions, linear advance with wrapping disabled, address roll-over at the top of memory, and start-over-step priority.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int ADDR_W  = 22;
  localparam int PITCH_W = 12;
  localparam int CNT_W   = 12;
  localparam int SEL_W   = 3;
  // Largest tile side is 2^(2^SEL_W-2); the in-tile row needs that many bits.
  localparam int TY_W    = (2 ** SEL_W) - 2;
  localparam int NUM_OPS = 3;

  typedef struct packed {
    logic load;
    logic x_adv;
    logic line_adv;
  } chan_cmd_t;
endpackage

// File: rtl/blit_pos_ctrl.sv
module blit_pos_ctrl import blit_pkg::*; #(
  parameter int CW = CNT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            step,
  input  logic [CW-1:0]   x_count,
  input  logic [CW-1:0]   y_count,
  output chan_cmd_t       cmd,
  output logic            x_ovf,
  output logic            y_ovf,
  output logic            done
);
  logic [CW-1:0] xpos_q, xpos_n, ypos_q, ypos_n, xcnt_q, ycnt_q;
  logic          xo_q, xo_n, yo_q, yo_n, done_q, done_n;
  logic          go, x_end, y_end, upd_en;

  assign go    = step && !done_q && !start;
  assign x_end = (xpos_q == xcnt_q);
  assign y_end = (ypos_q == ycnt_q);

  assign cmd.load     = start;
  assign cmd.x_adv    = go && !x_end;
  assign cmd.line_adv = go && x_end && !y_end;

  assign upd_en = start || go;

  always_comb begin
    xpos_n = xpos_q;
    ypos_n = ypos_q;
    xo_n   = xo_q;
    yo_n   = yo_q;
    done_n = done_q;
    if (start) begin
      xpos_n = '0;
      ypos_n = '0;
      xo_n   = 1'b0;
      yo_n   = 1'b0;
      done_n = 1'b0;
    end else if (go) begin
      xo_n = x_end;
      yo_n = x_end && y_end;
      if (!x_end) begin
        xpos_n = xpos_q + CW'(1);
      end else begin
        xpos_n = '0;
        if (!y_end) ypos_n = ypos_q + CW'(1);
        else        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xpos_q <= '0;
      ypos_q <= '0;
      xcnt_q <= '0;
      ycnt_q <= '0;
      xo_q   <= 1'b0;
      yo_q   <= 1'b0;
      done_q <= 1'b0;
    end else if (upd_en) begin
      xpos_q <= xpos_n;
      ypos_q <= ypos_n;
      xo_q   <= xo_n;
      yo_q   <= yo_n;
      done_q <= done_n;
      if (start) begin
        xcnt_q <= x_count;
        ycnt_q <= y_count;
      end
    end
  end

  assign x_ovf = xo_q;
  assign y_ovf = yo_q;
  assign done  = done_q;

  // R4: the X position never leaves 0..count
  a_r4_xpos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    xpos_q <= xcnt_q);
  // R8: finishing raises both overflow flags
  a_r8_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (xo_q && yo_q));
  // R9: finished state persists until a new start
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start) |=> done_q);
  // R9: flags frozen while finished
  a_r9_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start) |=> ($stable(xo_q) && $stable(yo_q)));
endmodule

// File: rtl/blit_tile_chan.sv
module blit_tile_chan import blit_pkg::*; #(
  parameter int AW       = ADDR_W,
  parameter int PW       = PITCH_W,
  parameter int SW       = SEL_W,
  parameter int TYW      = TY_W,
  parameter bit HAS_WRAP = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  chan_cmd_t       cmd,
  input  logic [AW-1:0]   base,
  input  logic [PW-1:0]   pitch,
  input  logic [SW-1:0]   xsel,
  input  logic [SW-1:0]   ysel,
  input  logic            x_neg,
  input  logic            y_neg,
  output logic [AW-1:0]   addr
);
  localparam logic [SW-1:0] SEL_NONE = '1;

  logic [AW-1:0]  line_q, line_n, xoff_q, xoff_n, xoff0_q;
  logic [TYW-1:0] ty_q, ty_n;
  logic [PW-1:0]  pitch_q;
  logic [SW-1:0]  xsel_q, ysel_q;
  logic           xneg_q, yneg_q;
  logic           upd_en;

  // start-time decomposition of the base address
  logic           ld_xw, ld_yw;
  logic [SW-1:0]  ld_kx, ld_ky;
  logic [SW:0]    ld_ksum;
  logic [AW-1:0]  ld_xm, ld_strip, ld_align;
  logic [TYW-1:0] ld_ywv, ld_ty;

  assign ld_xw    = HAS_WRAP && (xsel != SEL_NONE);
  assign ld_yw    = HAS_WRAP && (ysel != SEL_NONE);
  assign ld_kx    = ld_xw ? xsel : '0;
  assign ld_ky    = ld_yw ? ysel : '0;
  assign ld_ksum  = {1'b0, ld_kx} + {1'b0, ld_ky};
  assign ld_xm    = (AW'(1) << ld_kx) - AW'(1);
  assign ld_strip = base & ~ld_xm;
  assign ld_align = base & ~((AW'(1) << ld_ksum) - AW'(1));
  assign ld_ywv   = (TYW'(1) << ld_ky) - TYW'(1);
  assign ld_ty    = TYW'(ld_strip >> ld_kx) & ld_ywv;

  // run-time tile geometry from captured selections
  logic           xw_en, yw_en;
  logic [AW-1:0]  xm, lstep, span, xinc;
  logic [TYW-1:0] ywv;

  assign xw_en = HAS_WRAP && (xsel_q != SEL_NONE);
  assign yw_en = HAS_WRAP && (ysel_q != SEL_NONE);
  assign xm    = xw_en ? ((AW'(1) << xsel_q) - AW'(1)) : '0;
  assign ywv   = yw_en ? ((TYW'(1) << ysel_q) - TYW'(1)) : '0;
  assign lstep = AW'(pitch_q) + AW'(1);
  assign span  = lstep << ysel_q;
  assign xinc  = xneg_q ? (xoff_q - AW'(1)) : (xoff_q + AW'(1));

  assign upd_en = cmd.load || cmd.x_adv || cmd.line_adv;

  always_comb begin
    line_n = line_q;
    xoff_n = xoff_q;
    ty_n   = ty_q;
    if (cmd.load) begin
      xoff_n = base & ld_xm;
      if (ld_yw) begin
        ty_n   = ld_ty;
        line_n = ld_align;
      end else begin
        ty_n   = '0;
        line_n = ld_strip;
      end
    end else if (cmd.x_adv) begin
      xoff_n = xw_en ? (xinc & xm) : xinc;
    end else if (cmd.line_adv) begin
      xoff_n = xoff0_q;
      if (!yneg_q) begin
        line_n = line_q + lstep;
        if (yw_en) begin
          if (ty_q == ywv) begin
            ty_n   = '0;
            line_n = line_q + lstep - span;
          end else begin
            ty_n = ty_q + TYW'(1);
          end
        end
      end else begin
        line_n = line_q - lstep;
        if (yw_en) begin
          if (ty_q == '0) begin
            ty_n   = ywv;
            line_n = line_q - lstep + span;
          end else begin
            ty_n = ty_q - TYW'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      xoff_q  <= '0;
      xoff0_q <= '0;
      ty_q    <= '0;
      pitch_q <= '0;
      xsel_q  <= SEL_NONE;
      ysel_q  <= SEL_NONE;
      xneg_q  <= 1'b0;
      yneg_q  <= 1'b0;
    end else begin
      if (upd_en) begin
        line_q <= line_n;
        xoff_q <= xoff_n;
        ty_q   <= ty_n;
      end
      if (cmd.load) begin
        xoff0_q <= base & ld_xm;
        pitch_q <= pitch;
        xsel_q  <= xsel;
        ysel_q  <= ysel;
        xneg_q  <= x_neg;
        yneg_q  <= y_neg;
      end
    end
  end

  assign addr = line_q + xoff_q;

  // R3: wrapped column never escapes its tile
  a_r3_col_in_tile: assert property (@(posedge clk) disable iff (!rst_n)
    xw_en |-> ((xoff_q & ~xm) == '0));
  // R6: wrapped row never exceeds the tile height
  a_r6_row_in_tile: assert property (@(posedge clk) disable iff (!rst_n)
    yw_en |-> (ty_q <= ywv));
  // R9: without a command the address holds
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.load && !cmd.x_adv && !cmd.line_adv) |=> $stable(addr));
endmodule

// File: rtl/blit_addr_stepper.sv
module blit_addr_stepper import blit_pkg::*; #(
  parameter int AW = ADDR_W,
  parameter int PW = PITCH_W,
  parameter int CW = CNT_W,
  parameter int SW = SEL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            step,
  input  logic [AW-1:0]   dst_base,
  input  logic [AW-1:0]   src_base,
  input  logic [AW-1:0]   pat_base,
  input  logic [PW-1:0]   dst_pitch,
  input  logic [PW-1:0]   src_pitch,
  input  logic [PW-1:0]   pat_pitch,
  input  logic            x_neg,
  input  logic            y_neg,
  input  logic [SW-1:0]   src_xwrap,
  input  logic [SW-1:0]   src_ywrap,
  input  logic [SW-1:0]   pat_xwrap,
  input  logic [SW-1:0]   pat_ywrap,
  input  logic [CW-1:0]   x_count,
  input  logic [CW-1:0]   y_count,
  output logic [AW-1:0]   dst_addr,
  output logic [AW-1:0]   src_addr,
  output logic [AW-1:0]   pat_addr,
  output logic            x_ovf,
  output logic            y_ovf,
  output logic            done
);
  localparam int TYW = (2 ** SW) - 2;

  chan_cmd_t     cmd;
  logic [AW-1:0] base_a [NUM_OPS];
  logic [PW-1:0] pitch_a[NUM_OPS];
  logic [SW-1:0] xsel_a [NUM_OPS];
  logic [SW-1:0] ysel_a [NUM_OPS];
  logic [AW-1:0] addr_a [NUM_OPS];

  // operand 0 is the destination and never wraps
  assign base_a[0]  = dst_base;
  assign base_a[1]  = src_base;
  assign base_a[2]  = pat_base;
  assign pitch_a[0] = dst_pitch;
  assign pitch_a[1] = src_pitch;
  assign pitch_a[2] = pat_pitch;
  assign xsel_a[0]  = '1;
  assign xsel_a[1]  = src_xwrap;
  assign xsel_a[2]  = pat_xwrap;
  assign ysel_a[0]  = '1;
  assign ysel_a[1]  = src_ywrap;
  assign ysel_a[2]  = pat_ywrap;

  blit_pos_ctrl #(.CW(CW)) u_pos (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .x_count(x_count), .y_count(y_count), .cmd(cmd),
    .x_ovf(x_ovf), .y_ovf(y_ovf), .done(done)
  );

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    blit_tile_chan #(
      .AW(AW), .PW(PW), .SW(SW), .TYW(TYW), .HAS_WRAP(i != 0)
    ) u_chan (
      .clk(clk), .rst_n(rst_n), .cmd(cmd),
      .base(base_a[i]), .pitch(pitch_a[i]),
      .xsel(xsel_a[i]), .ysel(ysel_a[i]),
      .x_neg(x_neg), .y_neg(y_neg), .addr(addr_a[i])
    );
  end

  assign dst_addr = addr_a[0];
  assign src_addr = addr_a[1];
  assign pat_addr = addr_a[2];

  // R8: a rectangle end is always also a line end
  a_r8_y_needs_x: assert property (@(posedge clk) disable iff (!rst_n)
    y_ovf |-> x_ovf);
endmodule

// File: tb/blit_addr_stepper_tb_top.sv
`timescale 1ns/1ps
module blit_addr_stepper_tb_top;
  localparam int AW = 22, PW = 12, CW = 12, SW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, step, x_neg, y_neg;
  logic [AW-1:0] dst_base, src_base, pat_base, dst_addr, src_addr, pat_addr;
  logic [PW-1:0] dst_pitch, src_pitch, pat_pitch;
  logic [SW-1:0] src_xwrap, src_ywrap, pat_xwrap, pat_ywrap;
  logic [CW-1:0] x_count, y_count;
  logic x_ovf, y_ovf, done;

  blit_addr_stepper dut_i (.*);

  int checks = 0, failures = 0;

  // reference state
  logic [AW-1:0] m_line[3], m_col[3], m_col0[3];
  int            m_row[3];
  logic [AW-1:0] c_base[3];
  int            c_pitch[3], c_xs[3], c_ys[3];
  int            m_xpos, m_ypos, c_xc, c_yc;
  bit            m_xo, m_yo, m_done, c_xn, c_yn;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] m_addr(input int i);
    return m_line[i] + m_col[i];
  endfunction

  task automatic model_load();
    c_base[0] = dst_base; c_base[1] = src_base; c_base[2] = pat_base;
    c_pitch[0] = dst_pitch; c_pitch[1] = src_pitch; c_pitch[2] = pat_pitch;
    c_xs[0] = 7; c_xs[1] = src_xwrap; c_xs[2] = pat_xwrap;
    c_ys[0] = 7; c_ys[1] = src_ywrap; c_ys[2] = pat_ywrap;
    c_xn = x_neg; c_yn = y_neg; c_xc = x_count; c_yc = y_count;
    m_xpos = 0; m_ypos = 0; m_xo = 0; m_yo = 0; m_done = 0;
    for (int i = 0; i < 3; i++) begin
      int kx, ky;
      logic [AW-1:0] xm, strip;
      kx = (c_xs[i] == 7) ? 0 : c_xs[i];
      ky = (c_ys[i] == 7) ? 0 : c_ys[i];
      xm = AW'((1 << kx) - 1);
      strip = c_base[i] & ~xm;
      m_col[i] = c_base[i] & xm;
      m_col0[i] = m_col[i];
      if (c_ys[i] != 7) begin
        m_row[i] = int'(strip >> kx) & ((1 << ky) - 1);
        m_line[i] = (c_base[i] >> (kx + ky)) << (kx + ky);
      end else begin
        m_row[i] = 0;
        m_line[i] = strip;
      end
    end
  endtask

  // returns event: 0 idle, 1 load, 2 column, 3 line, 4 finish, 5 ignored
  task automatic model_update(input bit st, input bit stp, output int ev);
    ev = 0;
    if (st) begin model_load(); ev = 1; end
    else if (stp && m_done) ev = 5;
    else if (stp) begin
      bit xe, ye;
      xe = (m_xpos == c_xc);
      ye = (m_ypos == c_yc);
      m_xo = xe; m_yo = xe && ye;
      if (!xe) begin
        ev = 2;
        m_xpos++;
        for (int i = 0; i < 3; i++) begin
          m_col[i] = c_xn ? m_col[i] - 1 : m_col[i] + 1;
          if (c_xs[i] != 7) m_col[i] &= AW'((1 << c_xs[i]) - 1);
        end
      end else if (!ye) begin
        ev = 3;
        m_xpos = 0; m_ypos++;
        for (int i = 0; i < 3; i++) begin
          int st1, tw;
          st1 = c_pitch[i] + 1;
          m_col[i] = m_col0[i];
          if (c_ys[i] != 7) begin
            tw = (1 << c_ys[i]);
            if (!c_yn) begin
              m_line[i] = m_line[i] + AW'(st1);
              m_row[i]++;
              if (m_row[i] > tw - 1) begin
                m_row[i] = 0;
                m_line[i] = m_line[i] - AW'(st1 * tw);
              end
            end else begin
              m_line[i] = m_line[i] - AW'(st1);
              if (m_row[i] == 0) begin
                m_row[i] = tw - 1;
                m_line[i] = m_line[i] + AW'(st1 * tw);
              end else m_row[i]--;
            end
          end else begin
            m_line[i] = c_yn ? m_line[i] - AW'(st1) : m_line[i] + AW'(st1);
          end
        end
      end else begin
        ev = 4;
        m_xpos = 0;
        m_done = 1;
      end
    end
  endtask

  task automatic compare_all(input string td, input string to, input string tf);
    chk(td, "dst_addr", 32'(dst_addr), 32'(m_addr(0)));
    chk(to, "src_addr", 32'(src_addr), 32'(m_addr(1)));
    chk(to, "pat_addr", 32'(pat_addr), 32'(m_addr(2)));
    chk(tf, "x_ovf", 32'(x_ovf), 32'(m_xo));
    chk(tf, "y_ovf", 32'(y_ovf), 32'(m_yo));
    chk(tf, "done", 32'(done), 32'(m_done));
  endtask

  // called at a negative edge; applies inputs for one rising edge
  task automatic cycle(input bit st, input bit stp, input string ovr);
    int ev;
    string td, to, tf;
    start = st; step = stp;
    @(posedge clk);
    model_update(st, stp, ev);
    @(negedge clk);
    start = 1'b0; step = 1'b0;
    case (ev)
      1: begin td = "R2"; to = "R2"; tf = "R2"; end
      2: begin td = "R3"; to = "R3"; tf = "R4"; end
      3: begin td = "R5"; to = c_yn ? "R7" : "R6"; tf = "R4"; end
      4: begin td = "R8"; to = "R8"; tf = "R8"; end
      5: begin td = "R9"; to = "R9"; tf = "R9"; end
      default: begin td = "R9"; to = "R9"; tf = "R9"; end
    endcase
    if (ovr != "") begin td = ovr; to = ovr; tf = ovr; end
    compare_all(td, to, tf);
  endtask

  task automatic run_blit(input string ovr, input bit rnd_gaps);
    cycle(1'b1, 1'b0, ovr);
    while (!m_done) cycle(1'b0, rnd_gaps ? (($urandom % 4) != 0) : 1'b1, ovr);
    cycle(1'b0, 1'b1, "R9");
    cycle(1'b0, 1'b1, "R9");
  endtask

  task automatic set_cfg(input logic [AW-1:0] db, sb, pb, input int dp, sp, pp,
                         input int sx, sy, px, py, input int xc, yc, input bit xn, yn);
    dst_base = db; src_base = sb; pat_base = pb;
    dst_pitch = PW'(dp); src_pitch = PW'(sp); pat_pitch = PW'(pp);
    src_xwrap = SW'(sx); src_ywrap = SW'(sy); pat_xwrap = SW'(px); pat_ywrap = SW'(py);
    x_count = CW'(xc); y_count = CW'(yc); x_neg = xn; y_neg = yn;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5EED_0042);
    rst_n = 1'b0; start = 1'b0; step = 1'b0;
    set_cfg('0, '0, '0, 0, 0, 0, 7, 7, 7, 7, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) begin m_line[i] = '0; m_col[i] = '0; end
    m_xo = 0; m_yo = 0; m_done = 0;
    compare_all("R1", "R1", "R1");

    // R2/R6: tiled source and pattern, upward
    set_cfg(22'h001000, 22'h012345, 22'h000AB7, 79, 3, 1, 2, 1, 1, 2, 5, 4, 0, 0);
    run_blit("", 1'b0);
    // R7: both directions reversed
    set_cfg(22'h020000, 22'h012345, 22'h000AB7, 79, 3, 1, 2, 1, 1, 2, 5, 4, 1, 1);
    run_blit("", 1'b0);
    // R10: wrapping disabled on source, X only on pattern
    set_cfg(22'h000100, 22'h003333, 22'h000ABC, 9, 15, 7, 7, 7, 3, 7, 3, 3, 0, 1);
    run_blit("R10", 1'b0);
    // R11: roll-over at the top of memory
    set_cfg(22'h3FFFFE, 22'h3FFFFD, 22'h000001, 2, 1, 0, 7, 7, 7, 7, 4, 2, 0, 0);
    run_blit("R11", 1'b0);
    // R12: start and step together
    set_cfg(22'h000200, 22'h000404, 22'h000808, 7, 7, 7, 2, 2, 1, 1, 3, 1, 0, 0);
    cycle(1'b1, 1'b0, "R12");
    cycle(1'b0, 1'b1, "R12");
    cycle(1'b0, 1'b1, "R12");
    set_cfg(22'h000600, 22'h000000, 22'h000000, 3, 3, 3, 7, 7, 7, 7, 2, 2, 0, 0);
    cycle(1'b1, 1'b1, "R12");
    cycle(1'b0, 1'b1, "R12");

    // random operations
    for (int n = 0; n < 40; n++) begin
      set_cfg(AW'($urandom), AW'($urandom), AW'($urandom),
              $urandom % 64, $urandom % 64, $urandom % 64,
              ($urandom % 2) ? 7 : $urandom % 7, ($urandom % 2) ? 7 : $urandom % 7,
              ($urandom % 2) ? 7 : $urandom % 7, ($urandom % 2) ? 7 : $urandom % 7,
              $urandom % 6, $urandom % 9, 1'($urandom), 1'($urandom));
      run_blit("", 1'b1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule